// File: doc/BRIEF.md
# Smart-Card Character Retry Controller

This block handles errors one character at a time for the character-oriented smart-card protocol (T=0). It sits between a half-duplex character framer and the host-side registers. The framer reports each received character together with its parity verdict. The controller then makes one of three choices:

- accept the character and pass it to the host;
- refuse it by pulling the I/O line low in the guard time, so that the card repeats it;
- accept it as corrupt because repetition is inhibited or the retry budget is exhausted.

Characters sent in the other direction are repeated when the card signals a refusal.

Both directions count consecutive failures against a programmable maximum. When the maximum is reached, a sticky iteration flag is raised and the retry loop ends. A sticky flag records that the card refused at least one character. A saturating error total collects every receive parity error and every card refusal. The host reads that total, and the read clears it. The iteration flag and the refusal flag each have their own clear command.

Top module: `t0_retry_ctrl`

## Requirements
- R1: After a synchronous reset, the following outputs are all zero: `nack_drive`, `tx_busy`, `tx_send`, `rx_out_valid`, `iter_flag`, `nack_flag` and `err_count`.
- R2: A character captured with `rx_parity_ok`=1 appears on `rx_out_data` with `rx_out_valid`=1 and `rx_out_perr`=0 one cycle after the capture edge. No refusal pulse follows it.
- R3: A parity error under the limit is refused when refusal is not inhibited. The character is not delivered. `nack_drive` stays 0 for ETU_CYCLES/2 cycles after the capture edge, then is 1 for exactly ETU_CYCLES cycles.
- R4: With `cfg_inhibit_nack`=1, a parity error never produces `nack_drive`. The character is delivered with `rx_out_perr`=1, and the iteration flag is not touched.
- R5: With `cfg_limit_en`=1, let M = max(`cfg_max_iter`,1). The M-th consecutive parity error is delivered with `rx_out_perr`=1 and no refusal pulse, and it sets `iter_flag`. The consecutive count then restarts from zero.
- R6: A character received with correct parity resets the consecutive receive error count to zero.
- R7: `iter_flag` stays 1 until a `cmd_clr_iter` pulse clears it. A limit event in the same cycle as the clear wins, so the flag stays 1.
- R8: A `host_tx_load` while idle raises `tx_busy`. It also gives a one-cycle `tx_send` with the loaded byte. When `tx_done` arrives with `tx_nack`=0, `tx_busy` drops.
- R9: When `tx_done` arrives with `tx_nack`=1, `nack_flag` is set and stays set until `cmd_clr_nack`. The same byte is offered again on `tx_send` in the following cycle. The exception is the M-th consecutive refusal with `cfg_limit_en`=1: it ends the transfer (`tx_busy` drops), and it sets `iter_flag`. `tx_done` while idle is ignored.
- R10: `err_count` rises by one for each receive parity error and for each card refusal. It saturates at 2^ERR_W-1.
- R11: An `err_rd` pulse clears `err_count`. An error in the same cycle as the read is kept, so the count becomes 1.
- R12: With `cfg_limit_en`=0 and refusal not inhibited, every parity error is refused and `iter_flag` never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_iter | input | ITER_W | Consecutive failure limit (0 treated as 1) |
| cfg_inhibit_nack | input | 1 | Never refuse received characters |
| cfg_limit_en | input | 1 | Enable the consecutive failure limit |
| cmd_clr_iter | input | 1 | Clear the iteration flag |
| cmd_clr_nack | input | 1 | Clear the refusal-seen flag |
| err_rd | input | 1 | Host reads error total (clears it) |
| rx_char_valid | input | 1 | Framer has a character at start of guard time |
| rx_char_data | input | DATA_W | Received character |
| rx_parity_ok | input | 1 | Parity of received character was correct |
| rx_out_valid | output | 1 | Character accepted toward host |
| rx_out_data | output | DATA_W | Accepted character |
| rx_out_perr | output | 1 | Accepted character had a parity error |
| nack_drive | output | 1 | Pull the I/O line low (refusal) |
| host_tx_load | input | 1 | Host hands over a byte to send |
| host_tx_data | input | DATA_W | Byte to send |
| tx_busy | output | 1 | A transmit transfer is in progress |
| tx_send | output | 1 | Framer: start sending `tx_send_data` |
| tx_send_data | output | DATA_W | Byte offered to framer |
| tx_done | input | 1 | Framer finished a character |
| tx_nack | input | 1 | Card refused that character |
| iter_flag | output | 1 | Sticky: retry limit reached |
| nack_flag | output | 1 | Sticky: card refused a character |
| err_count | output | ERR_W | Saturating error total |

## Verification
The hardest situations to reach are the edges of the retry budget. One is a limit event that lands on the very cycle the host clears the iteration flag. Another is a chain of errors that a good character interrupts just short of the limit. The stimulus builds exact consecutive error chains under different limits, including a limit of zero. It places the clear command in the capture cycle of the final error. It also inserts a good character one error before the limit, so that a missing counter reset shows up as a missing refusal pulse. Saturation is reached with a narrowed counter and a run of inhibited errors. That run ends with a read and an error in the same cycle.

// File: rtl/t0r_pkg.sv
package t0r_pkg;

    typedef enum logic [1:0] {
        NT_IDLE,
        NT_WAIT,
        NT_DRIVE
    } nack_state_e;

    typedef enum logic [0:0] {
        TX_IDLE,
        TX_WAIT
    } tx_state_e;

    typedef enum logic [1:0] {
        RV_GOOD,
        RV_RETRY,
        RV_KEEP,
        RV_LIMIT
    } rx_verdict_e;

    typedef struct packed {
        logic rx_err;
        logic tx_refused;
        logic iter_hit;
    } t0r_evt_t;

    function automatic logic reached_limit(input logic en,
                                           input int unsigned fails,
                                           input int unsigned max_iter);
        int unsigned eff;
        eff = (max_iter == 0) ? 1 : max_iter;
        return en && (fails >= eff);
    endfunction

endpackage

// File: rtl/t0r_nack_timer.sv
module t0r_nack_timer #(
    parameter int ETU_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic drive
);
    import t0r_pkg::*;

    localparam int HALF = (ETU_CYCLES / 2 < 1) ? 1 : ETU_CYCLES / 2;
    localparam int CW   = $clog2(ETU_CYCLES + 1) + 1;

    nack_state_e   state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= NT_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                NT_IDLE: begin
                    if (start) begin
                        state_q <= NT_WAIT;
                        cnt_q   <= CW'(HALF - 1);
                    end
                end
                NT_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= NT_DRIVE;
                        cnt_q   <= CW'(ETU_CYCLES - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                NT_DRIVE: begin
                    if (cnt_q == '0) state_q <= NT_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= NT_IDLE;
            endcase
        end
    end

    assign drive = (state_q == NT_DRIVE);

    logic [CW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)        run_q <= '0;
        else if (drive) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    assert_nack_width_R3: assert property (@(posedge clk) disable iff (rst)
        drive |-> (run_q < CW'(ETU_CYCLES)));

endmodule

// File: rtl/t0r_rx_retry.sv
module t0r_rx_retry #(
    parameter int DATA_W = 8,
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ITER_W-1:0] cfg_max_iter,
    input  logic              cfg_inhibit_nack,
    input  logic              cfg_limit_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_ok,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_perr,
    output logic              nack_req,
    output logic              evt_err,
    output logic              evt_iter
);
    import t0r_pkg::*;

    logic [ITER_W-1:0] fails_q;
    logic [ITER_W:0]   fails_nx;
    rx_verdict_e       verdict;

    assign fails_nx = {1'b0, fails_q} + 1'b1;

    always_comb begin
        if (rx_par_ok)
            verdict = RV_GOOD;
        else if (cfg_inhibit_nack)
            verdict = RV_KEEP;
        else if (reached_limit(cfg_limit_en, 32'(fails_nx), 32'(cfg_max_iter)))
            verdict = RV_LIMIT;
        else
            verdict = RV_RETRY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fails_q   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (rx_valid) begin
                if (verdict == RV_RETRY) begin
                    if (fails_q != '1) fails_q <= fails_q + 1'b1;
                end else begin
                    fails_q   <= '0;
                    out_valid <= 1'b1;
                    out_data  <= rx_data;
                    out_perr  <= (verdict != RV_GOOD);
                end
            end
        end
    end

    assign nack_req = rx_valid && (verdict == RV_RETRY);
    assign evt_err  = rx_valid && !rx_par_ok;
    assign evt_iter = rx_valid && (verdict == RV_LIMIT);

    assert_out_follows_char_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rx_valid));

endmodule

// File: rtl/t0r_tx_retry.sv
module t0r_tx_retry #(
    parameter int DATA_W = 8,
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ITER_W-1:0] cfg_max_iter,
    input  logic              cfg_limit_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              done,
    input  logic              refused,
    output logic              busy,
    output logic              send,
    output logic [DATA_W-1:0] send_data,
    output logic              evt_refused,
    output logic              evt_iter
);
    import t0r_pkg::*;

    tx_state_e         state_q;
    logic [ITER_W-1:0] fails_q;
    logic [ITER_W:0]   fails_nx;
    logic              at_limit;

    assign fails_nx = {1'b0, fails_q} + 1'b1;
    assign at_limit = reached_limit(cfg_limit_en, 32'(fails_nx), 32'(cfg_max_iter));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= TX_IDLE;
            fails_q   <= '0;
            send      <= 1'b0;
            send_data <= '0;
        end else begin
            send <= 1'b0;
            case (state_q)
                TX_IDLE: begin
                    if (load) begin
                        state_q   <= TX_WAIT;
                        send_data <= load_data;
                        send      <= 1'b1;
                        fails_q   <= '0;
                    end
                end
                TX_WAIT: begin
                    if (done) begin
                        if (!refused || at_limit) begin
                            state_q <= TX_IDLE;
                            fails_q <= '0;
                        end else begin
                            if (fails_q != '1) fails_q <= fails_q + 1'b1;
                            send <= 1'b1;
                        end
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign busy        = (state_q == TX_WAIT);
    assign evt_refused = busy && done && refused;
    assign evt_iter    = evt_refused && at_limit;

    assert_send_in_transfer_R8: assert property (@(posedge clk) disable iff (rst)
        send |-> busy);
    assert_busy_ends_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

endmodule

// File: rtl/t0r_status.sv
module t0r_status #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  t0r_pkg::t0r_evt_t evt,
    input  logic             cmd_clr_iter,
    input  logic             cmd_clr_nack,
    input  logic             err_rd,
    output logic             iter_flag,
    output logic             nack_flag,
    output logic [ERR_W-1:0] err_count
);
    localparam logic [ERR_W+1:0] ERR_CAP = {2'b00, {ERR_W{1'b1}}};
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic [ERR_W-1:0] base;
    logic [1:0]       add;
    logic [ERR_W+1:0] sum_w;

    assign base  = err_rd ? '0 : err_count;
    assign add   = {1'b0, evt.rx_err} + {1'b0, evt.tx_refused};
    assign sum_w = {2'b00, base} + {{ERR_W{1'b0}}, add};

    always_ff @(posedge clk) begin
        if (rst) begin
            iter_flag <= 1'b0;
            nack_flag <= 1'b0;
            err_count <= '0;
        end else begin
            if (evt.iter_hit)      iter_flag <= 1'b1;
            else if (cmd_clr_iter) iter_flag <= 1'b0;
            if (evt.tx_refused)    nack_flag <= 1'b1;
            else if (cmd_clr_nack) nack_flag <= 1'b0;
            err_count <= (sum_w > ERR_CAP) ? ERR_MAX : sum_w[ERR_W-1:0];
        end
    end

    assert_iter_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(iter_flag) |-> $past(cmd_clr_iter));
    assert_nack_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(nack_flag) |-> $past(cmd_clr_nack));
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (err_count == ERR_MAX && !err_rd) |=> (err_count == ERR_MAX));
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
        err_rd |=> (err_count <= ERR_W'(2)));

endmodule

// File: rtl/t0_retry_ctrl.sv
module t0_retry_ctrl #(
    parameter int DATA_W     = 8,
    parameter int ITER_W     = 3,
    parameter int ERR_W      = 8,
    parameter int ETU_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ITER_W-1:0] cfg_max_iter,
    input  logic              cfg_inhibit_nack,
    input  logic              cfg_limit_en,
    input  logic              cmd_clr_iter,
    input  logic              cmd_clr_nack,
    input  logic              err_rd,
    input  logic              rx_char_valid,
    input  logic [DATA_W-1:0] rx_char_data,
    input  logic              rx_parity_ok,
    output logic              rx_out_valid,
    output logic [DATA_W-1:0] rx_out_data,
    output logic              rx_out_perr,
    output logic              nack_drive,
    input  logic              host_tx_load,
    input  logic [DATA_W-1:0] host_tx_data,
    output logic              tx_busy,
    output logic              tx_send,
    output logic [DATA_W-1:0] tx_send_data,
    input  logic              tx_done,
    input  logic              tx_nack,
    output logic              iter_flag,
    output logic              nack_flag,
    output logic [ERR_W-1:0]  err_count
);
    import t0r_pkg::*;

    logic     rx_nack_req, rx_evt_err, rx_evt_iter;
    logic     tx_evt_refused, tx_evt_iter;
    t0r_evt_t evt;

    t0r_rx_retry #(.DATA_W(DATA_W), .ITER_W(ITER_W)) u_rx (
        .clk(clk), .rst(rst),
        .cfg_max_iter(cfg_max_iter), .cfg_inhibit_nack(cfg_inhibit_nack),
        .cfg_limit_en(cfg_limit_en),
        .rx_valid(rx_char_valid), .rx_data(rx_char_data), .rx_par_ok(rx_parity_ok),
        .out_valid(rx_out_valid), .out_data(rx_out_data), .out_perr(rx_out_perr),
        .nack_req(rx_nack_req), .evt_err(rx_evt_err), .evt_iter(rx_evt_iter)
    );

    t0r_nack_timer #(.ETU_CYCLES(ETU_CYCLES)) u_nack (
        .clk(clk), .rst(rst), .start(rx_nack_req), .drive(nack_drive)
    );

    t0r_tx_retry #(.DATA_W(DATA_W), .ITER_W(ITER_W)) u_tx (
        .clk(clk), .rst(rst),
        .cfg_max_iter(cfg_max_iter), .cfg_limit_en(cfg_limit_en),
        .load(host_tx_load), .load_data(host_tx_data),
        .done(tx_done), .refused(tx_nack),
        .busy(tx_busy), .send(tx_send), .send_data(tx_send_data),
        .evt_refused(tx_evt_refused), .evt_iter(tx_evt_iter)
    );

    always_comb begin
        evt.rx_err     = rx_evt_err;
        evt.tx_refused = tx_evt_refused;
        evt.iter_hit   = rx_evt_iter || tx_evt_iter;
    end

    t0r_status #(.ERR_W(ERR_W)) u_status (
        .clk(clk), .rst(rst), .evt(evt),
        .cmd_clr_iter(cmd_clr_iter), .cmd_clr_nack(cmd_clr_nack), .err_rd(err_rd),
        .iter_flag(iter_flag), .nack_flag(nack_flag), .err_count(err_count)
    );

    assert_limit_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_out_valid && rx_out_perr && !cfg_inhibit_nack) |-> !u_nack.drive);

endmodule

// File: tb/t0_retry_ctrl_tb.sv
`timescale 1ns/1ps
module t0_retry_ctrl_tb_top;
    localparam int DATA_W  = 8;
    localparam int ITER_W  = 3;
    localparam int ERR_W   = 4;
    localparam int ETU     = 8;
    localparam int H       = ETU / 2;
    localparam int ERR_MAX = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ITER_W-1:0] cfg_max_iter = 3'd3;
    logic cfg_inhibit_nack = 1'b0, cfg_limit_en = 1'b1;
    logic cmd_clr_iter = 1'b0, cmd_clr_nack = 1'b0, err_rd = 1'b0;
    logic rx_char_valid = 1'b0, rx_parity_ok = 1'b1;
    logic [DATA_W-1:0] rx_char_data = '0, host_tx_data = '0;
    logic host_tx_load = 1'b0, tx_done = 1'b0, tx_nack = 1'b0;
    logic rx_out_valid, rx_out_perr, nack_drive, tx_busy, tx_send, iter_flag, nack_flag;
    logic [DATA_W-1:0] rx_out_data, tx_send_data;
    logic [ERR_W-1:0] err_count;

    always #4 clk = ~clk;

    t0_retry_ctrl #(.DATA_W(DATA_W), .ITER_W(ITER_W), .ERR_W(ERR_W), .ETU_CYCLES(ETU)) dut_i (
        .clk(clk), .rst(rst), .cfg_max_iter(cfg_max_iter),
        .cfg_inhibit_nack(cfg_inhibit_nack), .cfg_limit_en(cfg_limit_en),
        .cmd_clr_iter(cmd_clr_iter), .cmd_clr_nack(cmd_clr_nack), .err_rd(err_rd),
        .rx_char_valid(rx_char_valid), .rx_char_data(rx_char_data), .rx_parity_ok(rx_parity_ok),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .rx_out_perr(rx_out_perr),
        .nack_drive(nack_drive), .host_tx_load(host_tx_load), .host_tx_data(host_tx_data),
        .tx_busy(tx_busy), .tx_send(tx_send), .tx_send_data(tx_send_data),
        .tx_done(tx_done), .tx_nack(tx_nack), .iter_flag(iter_flag),
        .nack_flag(nack_flag), .err_count(err_count)
    );

    int checks = 0, errors = 0, exp_err = 0;
    bit finished = 0;
    logic [8:0] exp_q[$];

    task automatic chk(input bit c, input string r, input int act, input int exp);
        checks++;
        if (!c) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // scoreboard monitor: delivered characters (R2, R4, R5)
    always @(negedge clk) begin
        if (!rst && rx_out_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected delivery", int'({rx_out_perr, rx_out_data}), -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({rx_out_perr, rx_out_data} == e, "R2/R4/R5 delivered char",
                    int'({rx_out_perr, rx_out_data}), int'(e));
            end
        end
    end

    task automatic rx_char(input logic [7:0] d, input logic ok, input logic exp_nack,
                           input logic exp_del, input logic rd_same, input logic clr_same,
                           input string tag);
        int bad = 0;
        int hi = 0;
        logic want;
        if (exp_del) exp_q.push_back({~ok, d});
        if (rd_same) exp_err = 0;
        if (!ok && exp_err < ERR_MAX) exp_err++;
        @(negedge clk);
        rx_char_valid = 1'b1; rx_char_data = d; rx_parity_ok = ok;
        err_rd = rd_same; cmd_clr_iter = clr_same;
        @(negedge clk);
        rx_char_valid = 1'b0; err_rd = 1'b0; cmd_clr_iter = 1'b0;
        chk(int'(err_count) == exp_err, {tag, " R10 err_count"}, int'(err_count), exp_err);
        for (int i = 0; i <= H + ETU; i++) begin
            want = exp_nack && (i >= H) && (i < H + ETU);
            if (nack_drive !== want) bad++;
            if (nack_drive) hi++;
            @(negedge clk);
        end
        chk(bad == 0, {tag, " R3 nack_drive window"}, hi, exp_nack ? ETU : 0);
    endtask

    task automatic pulse_clr_iter();
        @(negedge clk); cmd_clr_iter = 1'b1;
        @(negedge clk); cmd_clr_iter = 1'b0;
    endtask

    task automatic tx_load(input logic [7:0] d);
        @(negedge clk); host_tx_load = 1'b1; host_tx_data = d;
        @(negedge clk); host_tx_load = 1'b0;
        chk(tx_send && tx_busy && tx_send_data == d, "R8 load offers byte",
            int'({tx_send, tx_busy, tx_send_data}), int'({2'b11, d}));
    endtask

    task automatic tx_reply(input logic nk, input logic exp_resend, input logic exp_busy,
                            input logic [7:0] d, input string tag);
        if (nk && exp_err < ERR_MAX) exp_err++;
        repeat (3) @(negedge clk);
        tx_done = 1'b1; tx_nack = nk;
        @(negedge clk); tx_done = 1'b0; tx_nack = 1'b0;
        chk(tx_send == exp_resend && tx_busy == exp_busy && (!exp_resend || tx_send_data == d),
            tag, int'({tx_send, tx_busy, tx_send_data}), int'({exp_resend, exp_busy, d}));
        chk(int'(err_count) == exp_err, "R10 err_count after tx reply", int'(err_count), exp_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!nack_drive && !tx_busy && !tx_send && !rx_out_valid && !iter_flag && !nack_flag
            && err_count == 0, "R1 reset state", int'({nack_drive, tx_busy, iter_flag, err_count}), 0);
        rst = 1'b0;
        @(negedge clk);

        // limit enabled, M = 3
        rx_char(8'hA5, 1, 0, 1, 0, 0, "R2 good char");
        rx_char(8'h11, 0, 1, 0, 0, 0, "R3 first error");
        rx_char(8'h11, 0, 1, 0, 0, 0, "R6 second error");
        rx_char(8'h22, 1, 0, 1, 0, 0, "R6 good resets chain");
        rx_char(8'h33, 0, 1, 0, 0, 0, "R6 chain 1");
        rx_char(8'h33, 0, 1, 0, 0, 0, "R6 chain 2");
        rx_char(8'h33, 0, 0, 1, 0, 0, "R5 limit reached");
        chk(iter_flag == 1, "R5 iter_flag set", iter_flag, 1);
        repeat (5) @(negedge clk);
        chk(iter_flag == 1, "R7 iter_flag sticky", iter_flag, 1);
        pulse_clr_iter();
        chk(iter_flag == 0, "R7 iter_flag cleared", iter_flag, 0);

        rx_char(8'h44, 0, 1, 0, 0, 0, "R7 chain 1");
        rx_char(8'h44, 0, 1, 0, 0, 0, "R7 chain 2");
        rx_char(8'h44, 0, 0, 1, 0, 1, "R7 limit with clear");
        chk(iter_flag == 1, "R7 set wins over clear", iter_flag, 1);
        pulse_clr_iter();

        cfg_max_iter = 3'd0;
        rx_char(8'h55, 0, 0, 1, 0, 0, "R5 max zero");
        chk(iter_flag == 1, "R5 max zero sets flag", iter_flag, 1);
        pulse_clr_iter();

        cfg_max_iter = 3'd3; cfg_inhibit_nack = 1'b1;
        rx_char(8'h66, 0, 0, 1, 0, 0, "R4 inhibited error");
        chk(iter_flag == 0, "R4 no iteration", iter_flag, 0);
        cfg_inhibit_nack = 1'b0;

        cfg_limit_en = 1'b0; cfg_max_iter = 3'd1;
        for (int k = 0; k < 4; k++) rx_char(8'h77, 0, 1, 0, 0, 0, "R12 unlimited retries");
        chk(iter_flag == 0, "R12 no iteration", iter_flag, 0);
        rx_char(8'h78, 1, 0, 1, 0, 0, "R6 good after unlimited");

        // transmit side, M = 2
        cfg_limit_en = 1'b1; cfg_max_iter = 3'd2;
        tx_load(8'h3C);
        tx_reply(1, 1, 1, 8'h3C, "R9 refusal resends");
        chk(nack_flag == 1, "R9 nack_flag set", nack_flag, 1);
        tx_reply(0, 0, 0, 8'h3C, "R8 accepted ends");
        repeat (3) @(negedge clk);
        chk(nack_flag == 1, "R9 nack_flag sticky", nack_flag, 1);
        @(negedge clk); cmd_clr_nack = 1'b1;
        @(negedge clk); cmd_clr_nack = 1'b0;
        chk(nack_flag == 0, "R9 nack_flag cleared", nack_flag, 0);
        tx_load(8'h5A);
        tx_reply(1, 1, 1, 8'h5A, "R9 first refusal");
        tx_reply(1, 0, 0, 8'h5A, "R9 limit stops resend");
        chk(iter_flag == 1, "R9 tx limit sets iter_flag", iter_flag, 1);
        pulse_clr_iter();
        @(negedge clk); cmd_clr_nack = 1'b1;
        @(negedge clk); cmd_clr_nack = 1'b0;
        @(negedge clk); tx_done = 1'b1; tx_nack = 1'b1;
        @(negedge clk); tx_done = 1'b0; tx_nack = 1'b0;
        chk(nack_flag == 0 && !tx_send && !tx_busy, "R9 idle done ignored",
            int'({nack_flag, tx_send, tx_busy}), 0);
        chk(int'(err_count) == exp_err, "R9 idle done no count", int'(err_count), exp_err);

        // error total
        @(negedge clk); err_rd = 1'b1;
        @(negedge clk); err_rd = 1'b0;
        exp_err = 0;
        chk(err_count == 0, "R11 read clears", int'(err_count), 0);
        cfg_inhibit_nack = 1'b1;
        for (int k = 0; k < 18; k++) rx_char(8'(k), 0, 0, 1, 0, 0, "R10 saturate");
        chk(int'(err_count) == ERR_MAX, "R10 saturated", int'(err_count), ERR_MAX);
        rx_char(8'h99, 0, 0, 1, 1, 0, "R11 read with error");
        chk(err_count == 1, "R11 error kept on read", int'(err_count), 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all deliveries seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "R1 watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule